// File: doc/BRIEF.md
# Prioritised Interrupt Dispatcher

This block decides, each time the processor core reaches an instruction boundary, whether to enter an interrupt handler. It owns the global interrupt enable, holds the pending-request register for five sources, and takes an external five-bit per-source enable mask. A source counts as pending only when its enable bit and its request bit are both set. The lowest-numbered pending source wins.

When a source is taken, the block clears that request bit and the global enable, and releases the core from its halted state. For exactly one clock it also raises a take strobe with the handler address. On that strobe the core saves its program counter and jumps to the handler. The core sends disable, enable, return-from-handler and halt commands as single-cycle pulses. Peripherals raise requests through a set-bit vector that is merged into the request register every cycle.

Top module: `irq_dispatch`

## Requirements
- R1: A source is pending only when its `irq_en_i` bit and its `irq_req_o` bit are both 1. A boundary with no pending source produces no take.
- R2: When several sources are pending, the one with the lowest bit index is taken. Bit 0 has the highest priority.
- R3: The handler address for source k is 0x0040 + 8*k, so sources 0..4 map to 0x40, 0x48, 0x50, 0x58 and 0x60. It appears on `vector_o` while `take_o` is high.
- R4: The request register updates as (old & ~taken_bit) | `req_set_i`. A new request on another bit in the take cycle is kept, and request bits the take did not select are unchanged.
- R5: A take clears the global enable. No source is taken while the global enable (`ime_o`) is 0.
- R6: A take is evaluated only in a cycle where `boundary_i` is 1. `take_o` rises on the clock edge that ends that cycle and lasts exactly one clock.
- R7: `cmd_halt_i` sets `halted_o`. A take clears `halted_o`, and the take wins over a halt command in the same cycle.
- R8: `cmd_di_i` clears the global enable. `cmd_ei_i` or `cmd_reti_i` sets it, with disable winning if both arrive together. A take in the same cycle overrides an enable command.
- R9: After reset, the global enable, all request bits, `halted_o` and `take_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary_i | input | 1 | Core is at an instruction boundary this cycle |
| irq_en_i | input | 5 | Per-source enable mask |
| req_set_i | input | 5 | New request bits to merge into the request register |
| cmd_di_i | input | 1 | Disable-interrupts command pulse |
| cmd_ei_i | input | 1 | Enable-interrupts command pulse |
| cmd_reti_i | input | 1 | Return-from-handler command pulse |
| cmd_halt_i | input | 1 | Core enters the halted state |
| irq_req_o | output | 5 | Current request register |
| ime_o | output | 1 | Global interrupt enable |
| halted_o | output | 1 | Core is halted |
| take_o | output | 1 | One-clock strobe: save PC and jump |
| vector_o | output | 16 | Handler address of the taken source |

## Verification
Every result is registered, so every effect of the inputs driven in one cycle (take, handler address, request bits, enable and halt state) is due exactly one clock edge later. The bench drives each cycle on the falling edge. It pushes the outcome predicted by the requirements into a queue, and a monitor pops it 2 ns after the next rising edge and compares it there. Because each cycle produces exactly one queue entry, a take that arrives a cycle early or late, or a strobe that lasts longer than one clock, shows up as a mismatch.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
    parameter int IRQ_SRC_DEF   = 5;
    parameter int IRQ_ADDR_DEF  = 16;
    parameter int IRQ_BASE_DEF  = 16'h0040;
    parameter int IRQ_STEP_DEF  = 8;

    // global-enable next value from commands, before any take override
    function automatic logic ime_after_cmd(input logic cur, input logic di,
                                           input logic ei, input logic reti);
        if (di)
            return 1'b0;
        else if (ei || reti)
            return 1'b1;
        else
            return cur;
    endfunction
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N     = 5,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     pend_i,
    output logic             any_o,
    output logic [N-1:0]     onehot_o,
    output logic [IDX_W-1:0] idx_o
);
    logic [N:0] lower;

    assign lower[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign lower[i+1]  = lower[i] | pend_i[i];
        assign onehot_o[i] = pend_i[i] & ~lower[i];
    end

    assign any_o = lower[N];

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot_o[i])
                idx_o = idx_o | IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen #(
    parameter int N      = 5,
    parameter int IDX_W  = (N > 1) ? $clog2(N) : 1,
    parameter int ADDR_W = 16,
    parameter int BASE   = 16'h0040,
    parameter int STEP   = 8
) (
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] vec_o
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STEP);

    assign vec_o = BASE_A + (ADDR_W'(idx_i) * STEP_A);
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
    import irq_dispatch_pkg::*;
#(
    parameter int N      = IRQ_SRC_DEF,
    parameter int ADDR_W = IRQ_ADDR_DEF,
    parameter int BASE   = IRQ_BASE_DEF,
    parameter int STEP   = IRQ_STEP_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic [N-1:0]      irq_en_i,
    input  logic [N-1:0]      req_set_i,
    input  logic              cmd_di_i,
    input  logic              cmd_ei_i,
    input  logic              cmd_reti_i,
    input  logic              cmd_halt_i,
    output logic [N-1:0]      irq_req_o,
    output logic              ime_o,
    output logic              halted_o,
    output logic              take_o,
    output logic [ADDR_W-1:0] vector_o
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [N-1:0]      req;
        logic              ime;
        logic              halted;
        logic              take;
        logic [ADDR_W-1:0] vec;
    } state_t;

    state_t state_d, state_q;

    logic [N-1:0]      pend;
    logic              pend_any;
    logic [N-1:0]      pick_oh;
    logic [IDX_W-1:0]  pick_idx;
    logic [ADDR_W-1:0] pick_vec;
    logic              take_now;

    assign pend = irq_en_i & state_q.req;

    irq_prio_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
        .pend_i   (pend),
        .any_o    (pend_any),
        .onehot_o (pick_oh),
        .idx_o    (pick_idx)
    );

    irq_vec_gen #(.N(N), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
                  .BASE(BASE), .STEP(STEP)) u_vec (
        .idx_i (pick_idx),
        .vec_o (pick_vec)
    );

    assign take_now = boundary_i & state_q.ime & pend_any;

    always_comb begin
        state_d      = state_q;
        state_d.take = take_now;
        state_d.req  = (state_q.req & ~(take_now ? pick_oh : '0)) | req_set_i;
        state_d.ime  = ime_after_cmd(state_q.ime, cmd_di_i, cmd_ei_i, cmd_reti_i);
        if (cmd_halt_i)
            state_d.halted = 1'b1;
        if (take_now) begin
            state_d.ime    = 1'b0;
            state_d.halted = 1'b0;
            state_d.vec    = pick_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_req_o = state_q.req;
    assign ime_o     = state_q.ime;
    assign halted_o  = state_q.halted;
    assign take_o    = state_q.take;
    assign vector_o  = state_q.vec;
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
    parameter int N      = 5,
    parameter int ADDR_W = 16,
    parameter int BASE   = 16'h0040,
    parameter int STEP   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              boundary_i,
    input logic [N-1:0]      req_set_i,
    input logic [N-1:0]      irq_req_o,
    input logic              ime_o,
    input logic              halted_o,
    input logic              take_o,
    input logic [ADDR_W-1:0] vector_o
);
    // R5
    ime_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ime_o) |-> !take_o);

    // R5
    ime_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !ime_o);

    // R6
    at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(boundary_i));

    // R6
    one_clock_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    // R7
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !halted_o);

    // R4
    single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && $past(req_set_i) == '0) |->
            $countones($past(irq_req_o) & ~irq_req_o) == 1);

    // R3
    vec_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (vector_o >= ADDR_W'(BASE)) &&
                   (((vector_o - ADDR_W'(BASE)) % ADDR_W'(STEP)) == '0));
endmodule

bind irq_dispatch irq_dispatch_chk #(
    .N(N), .ADDR_W(ADDR_W), .BASE(BASE), .STEP(STEP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary_i (boundary_i),
    .req_set_i  (req_set_i),
    .irq_req_o  (irq_req_o),
    .ime_o      (ime_o),
    .halted_o   (halted_o),
    .take_o     (take_o),
    .vector_o   (vector_o)
);

// File: tb/irq_dispatch_tb.sv
module irq_dispatch_tb;
    localparam int N = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary_i = 1'b0;
    logic [N-1:0] irq_en_i = '0;
    logic [N-1:0] req_set_i = '0;
    logic        cmd_di_i = 1'b0, cmd_ei_i = 1'b0, cmd_reti_i = 1'b0, cmd_halt_i = 1'b0;
    logic [N-1:0] irq_req_o;
    logic        ime_o, halted_o, take_o;
    logic [15:0] vector_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic [N-1:0] req;
        logic         ime;
        logic         halted;
        logic         take;
        logic [15:0]  vec;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    logic [N-1:0] m_req = '0;
    logic         m_ime = 1'b0;
    logic         m_halt = 1'b0;

    always #10 clk = ~clk;

    irq_dispatch u_dut (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .irq_en_i(irq_en_i),
        .req_set_i(req_set_i), .cmd_di_i(cmd_di_i), .cmd_ei_i(cmd_ei_i),
        .cmd_reti_i(cmd_reti_i), .cmd_halt_i(cmd_halt_i), .irq_req_o(irq_req_o),
        .ime_o(ime_o), .halted_o(halted_o), .take_o(take_o), .vector_o(vector_o)
    );

    // cmd bits: {halt, reti, ei, di}
    task automatic drive(input logic bnd, input logic [N-1:0] en,
                         input logic [N-1:0] set, input logic [3:0] cmd,
                         input string tag);
        exp_t e;
        int   k;
        logic tk;
        boundary_i = bnd; irq_en_i = en; req_set_i = set;
        cmd_di_i = cmd[0]; cmd_ei_i = cmd[1]; cmd_reti_i = cmd[2]; cmd_halt_i = cmd[3];
        k = -1;
        for (int i = N - 1; i >= 0; i--) if (en[i] && m_req[i]) k = i;
        tk = bnd && m_ime && (k >= 0);
        e.take = tk;
        e.vec  = tk ? 16'(16'h0040 + 8 * k) : 16'h0;
        if (tk) m_req[k] = 1'b0;
        m_req = m_req | set;
        if (cmd[0]) m_ime = 1'b0;
        else if (cmd[1] || cmd[2]) m_ime = 1'b1;
        if (cmd[3]) m_halt = 1'b1;
        if (tk) begin m_ime = 1'b0; m_halt = 1'b0; end
        e.req = m_req; e.ime = m_ime; e.halted = m_halt;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    // monitor: results are due one edge after the driven cycle
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (take_o !== e.take || irq_req_o !== e.req || ime_o !== e.ime ||
                halted_o !== e.halted || (e.take && vector_o !== e.vec)) begin
                fails++;
                $display("FAIL %s: take=%b vec=%h req=%b ime=%b halt=%b expected take=%b vec=%h req=%b ime=%b halt=%b",
                         t, take_o, vector_o, irq_req_o, ime_o, halted_o,
                         e.take, e.vec, e.req, e.ime, e.halted);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (take_o !== 1'b0 || ime_o !== 1'b0 || irq_req_o !== '0 || halted_o !== 1'b0) begin
            fails++;
            $display("FAIL R9: take=%b ime=%b req=%b halt=%b expected all zero",
                     take_o, ime_o, irq_req_o, halted_o);
        end
        drive(0, 5'h1F, 5'h00, 4'b0010, "R8");   // enable
        drive(1, 5'h1F, 5'h00, 4'b0000, "R1");   // nothing requested
        drive(0, 5'h1F, 5'b01010, 4'b0000, "R4");
        drive(1, 5'h1F, 5'h00, 4'b0000, "R2");   // bit1 beats bit3 -> 0x48
        drive(1, 5'h1F, 5'h00, 4'b0000, "R5");   // enable now clear
        drive(0, 5'h1F, 5'h00, 4'b0100, "R8");   // return command sets enable
        drive(1, 5'b10111, 5'h00, 4'b0000, "R1"); // bit3 masked
        drive(1, 5'h1F, 5'b00001, 4'b0000, "R4"); // take bit3 -> 0x58, keep new bit0
        drive(0, 5'h1F, 5'h00, 4'b1010, "R7");   // halt + enable
        drive(0, 5'h1F, 5'h00, 4'b0000, "R6");   // pending but no boundary
        drive(1, 5'h1F, 5'h00, 4'b0000, "R7");   // take bit0 -> 0x40, wake
        drive(0, 5'h1F, 5'b10000, 4'b0011, "R8"); // di and ei together -> off
        drive(1, 5'h1F, 5'h00, 4'b1010, "R8");   // enable + halt, no take yet
        drive(1, 5'h1F, 5'h00, 4'b1010, "R7");   // take 0x60 beats halt and ei
        drive(0, 5'h1F, 5'h1F, 4'b0010, "R3");
        for (int j = 0; j < N; j++) begin
            drive(1, 5'h1F, 5'h00, 4'b0000, "R3"); // take in order 0x40..0x60
            drive(0, 5'h1F, 5'h00, 4'b0100, "R2");
        end
        drive(0, 5'h00, 5'h00, 4'b0000, "R6");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule